// File: doc/BRIEF.md
# Reorder Buffer with In-Entry Results

This block tracks in-flight operations for an out-of-order core. Operations enter a circular buffer in program order, up to several per cycle, and each receives the index of its slot as a tag. No separate rename register pool exists: every slot carries a result field that acts as the renamed copy of its destination. A small map remembers, for each architectural register, whether its newest value is committed or still owned by an in-flight slot.

Execution units may finish in any order. A writeback names a slot by tag, stores the value there and marks the slot complete. Retirement walks from the oldest slot, takes up to a fixed number of consecutive complete slots per cycle, and copies their results into a committed register file. A dispatch stage asks the lookup ports where a source operand lives: it gets a ready value (committed, stored in a slot, or forwarded from a writeback in the same cycle) or the tag of the slot that will produce it. A flush discards everything in flight and points every register back at its committed value.

Lookups and the ready signal reflect the state before this cycle's allocations; dependencies within one allocation group are resolved by the caller.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty, no retire lane is active, allocation is accepted, and every register looks up as ready with committed value 0.
- R2: Valid allocation lanes receive consecutive tags starting at the tail, in lane order, skipping invalid lanes; tag DEPTH-1 is followed by tag 0.
- R3: `alloc_ready` is low when the free slot count is smaller than the number of valid lanes; no slot is taken in such a cycle.
- R4: A writeback stores its data in the slot named by its tag and marks it complete, in any order relative to program order.
- R5: A lookup of a register whose newest producer is incomplete returns ready low and that producer's tag.
- R6: A lookup whose producer receives a writeback in the same cycle returns ready high with the written data.
- R7: Retirement takes at most RET_W slots per cycle, only consecutive complete slots starting at the oldest; an incomplete oldest slot blocks all younger ones. `ret_vld` lane i marks the i-th retiring slot.
- R8: A retiring slot with its destination flag set writes its result into the committed file one cycle later; a slot without it leaves the committed file unchanged.
- R9: At retirement a register mapping is cleared only if it still names the retiring slot; a younger producer keeps the mapping.
- R10: A register maps to its youngest producer; within one group the highest valid lane wins, and among slots retiring together the youngest write lands last.
- R11: A flush empties the buffer, sets every mapping to committed, keeps the committed file, ignores allocation and retirement in its cycle, and restarts tags at 0.
- R12: Exactly DEPTH slots can be outstanding; when full, a request of one lane sees `alloc_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight slots |
| alloc_vld | input | ALLOC_W | Allocation request per lane |
| alloc_hd | input | ALLOC_W | Lane writes a destination register |
| alloc_dst | input | ALLOC_W*AW | Destination register id per lane |
| alloc_ready | output | 1 | Enough free slots for all valid lanes |
| alloc_tag | output | ALLOC_W*TW | Tag each lane receives |
| wb_vld | input | WB_W | Writeback valid per port |
| wb_tag | input | WB_W*TW | Slot written per port |
| wb_data | input | WB_W*DW | Result per port |
| lk_reg | input | LK_W*AW | Source register per lookup port |
| lk_ready | output | LK_W | Value available |
| lk_val | output | LK_W*DW | Source value when ready |
| lk_tag | output | LK_W*TW | Producer tag when a producer is in flight |
| ret_vld | output | RET_W | Retire lane active this cycle |

## Verification
The hardest situation to reach is a retirement that must leave a mapping alone because a younger producer of the same register is still in flight, together with several slots of one register retiring in a single cycle. The stimulus builds it by allocating the same register twice in separate cycles and then twice within one group, completing the older slots out of order while the oldest slot is held incomplete, then releasing them so that three retire together. A second hard case is the wrap of the tag ring at full occupancy: the bench advances the head by one slot first, then fills all slots so the last group crosses from the top tag to tag 0, and then frees only two slots to see a three-lane request refused.

// File: rtl/rob_pkg.sv
package rob_pkg;

   typedef enum logic [1:0] {
      SRC_ARCH  = 2'd0,
      SRC_ENTRY = 2'd1,
      SRC_FWD   = 2'd2,
      SRC_WAIT  = 2'd3
   } lk_src_e;

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rob_ring_add.sv
module rob_ring_add #(
   parameter int DEPTH = 72,
   parameter int OW    = 7,
   localparam int TW   = $clog2(DEPTH)
) (
   input  logic [TW-1:0] base_i,
   input  logic [OW-1:0] off_i,
   output logic [TW-1:0] sum_o
);
   generate
      if (rob_pkg::is_pow2(DEPTH)) begin : g_pow2
         assign sum_o = TW'(32'(base_i) + 32'(off_i));
      end else begin : g_mod
         always_comb begin
            int unsigned s;
            s = 32'(base_i) + 32'(off_i);
            if (s >= DEPTH) s = s - DEPTH;
            sum_o = TW'(s);
         end
      end
   endgenerate
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
   parameter int DEPTH   = 72,
   parameter int DW      = 32,
   parameter int NARCH   = 16,
   parameter int ALLOC_W = 3,
   parameter int WB_W    = 3,
   parameter int RET_W   = 3,
   localparam int TW     = $clog2(DEPTH),
   localparam int AW     = $clog2(NARCH)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           flush_i,
   input  logic [ALLOC_W-1:0]             al_we_i,
   input  logic [ALLOC_W-1:0][TW-1:0]     al_idx_i,
   input  logic [ALLOC_W-1:0][AW-1:0]     al_dst_i,
   input  logic [ALLOC_W-1:0]             al_hd_i,
   input  logic [WB_W-1:0]                wb_vld_i,
   input  logic [WB_W-1:0][TW-1:0]        wb_tag_i,
   input  logic [WB_W-1:0][DW-1:0]        wb_data_i,
   input  logic [RET_W-1:0]               rt_we_i,
   input  logic [RET_W-1:0][TW-1:0]       rt_idx_i,
   output logic [DEPTH-1:0]               done_o,
   output logic [DEPTH-1:0][DW-1:0]       res_o,
   output logic [DEPTH-1:0][AW-1:0]       dst_o,
   output logic [DEPTH-1:0]               hd_o
);
   logic [DEPTH-1:0]         live_q;
   logic [DEPTH-1:0]         done_q;
   logic [DEPTH-1:0][DW-1:0] res_q;
   logic [DEPTH-1:0][AW-1:0] dst_q;
   logic [DEPTH-1:0]         hd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         done_q <= '0;
         res_q  <= '0;
         dst_q  <= '0;
         hd_q   <= '0;
      end else if (flush_i) begin
         live_q <= '0;
         done_q <= '0;
      end else begin
         for (int r = 0; r < RET_W; r++) begin
            if (rt_we_i[r]) live_q[rt_idx_i[r]] <= 1'b0;
         end
         for (int w = 0; w < WB_W; w++) begin
            if (wb_vld_i[w] && (32'(wb_tag_i[w]) < DEPTH) && live_q[wb_tag_i[w]]) begin
               done_q[wb_tag_i[w]] <= 1'b1;
               res_q[wb_tag_i[w]]  <= wb_data_i[w];
            end
         end
         for (int a = 0; a < ALLOC_W; a++) begin
            if (al_we_i[a]) begin
               live_q[al_idx_i[a]] <= 1'b1;
               done_q[al_idx_i[a]] <= 1'b0;
               dst_q[al_idx_i[a]]  <= al_dst_i[a];
               hd_q[al_idx_i[a]]   <= al_hd_i[a];
            end
         end
      end
   end

   assign done_o = done_q;
   assign res_o  = res_q;
   assign dst_o  = dst_q;
   assign hd_o   = hd_q;

   generate
      for (genvar a = 0; a < ALLOC_W; a++) begin : g_al_chk
         p_alloc_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
            al_we_i[a] |-> !live_q[al_idx_i[a]]);
      end
      for (genvar w = 0; w < WB_W; w++) begin : g_wb_chk
         p_wb_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_vld_i[w] && !flush_i) |-> live_q[wb_tag_i[w]]);
      end
      for (genvar r = 0; r < RET_W; r++) begin : g_rt_chk
         p_retire_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rt_we_i[r] |-> (live_q[rt_idx_i[r]] && done_q[rt_idx_i[r]]));
      end
   endgenerate
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
   parameter int DEPTH   = 72,
   parameter int NARCH   = 16,
   parameter int ALLOC_W = 3,
   parameter int RET_W   = 3,
   localparam int TW     = $clog2(DEPTH),
   localparam int AW     = $clog2(NARCH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush_i,
   input  logic [ALLOC_W-1:0]           al_we_i,
   input  logic [ALLOC_W-1:0][AW-1:0]   al_dst_i,
   input  logic [ALLOC_W-1:0]           al_hd_i,
   input  logic [ALLOC_W-1:0][TW-1:0]   al_tag_i,
   input  logic [RET_W-1:0]             rt_we_i,
   input  logic [RET_W-1:0][AW-1:0]     rt_dst_i,
   input  logic [RET_W-1:0]             rt_hd_i,
   input  logic [RET_W-1:0][TW-1:0]     rt_tag_i,
   output logic [NARCH-1:0]             busy_o,
   output logic [NARCH-1:0][TW-1:0]     tag_o
);
   logic [NARCH-1:0]         busy_q;
   logic [NARCH-1:0][TW-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
         tag_q  <= '0;
      end else if (flush_i) begin
         busy_q <= '0;
      end else begin
         for (int r = 0; r < RET_W; r++) begin
            if (rt_we_i[r] && rt_hd_i[r] && busy_q[rt_dst_i[r]] &&
                (tag_q[rt_dst_i[r]] == rt_tag_i[r]))
               busy_q[rt_dst_i[r]] <= 1'b0;
         end
         for (int a = 0; a < ALLOC_W; a++) begin
            if (al_we_i[a] && al_hd_i[a]) begin
               busy_q[al_dst_i[a]] <= 1'b1;
               tag_q[al_dst_i[a]]  <= al_tag_i[a];
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign tag_o  = tag_q;

   p_flush_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (busy_q == '0));

   p_younger_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_i && rt_we_i[0] && rt_hd_i[0] && busy_q[rt_dst_i[0]] &&
       (tag_q[rt_dst_i[0]] != rt_tag_i[0]))
      |=> busy_q[$past(rt_dst_i[0])]);
endmodule

// File: rtl/rob_commit_file.sv
module rob_commit_file #(
   parameter int NARCH = 16,
   parameter int DW    = 32,
   parameter int RET_W = 3,
   localparam int AW   = $clog2(NARCH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [RET_W-1:0]           rt_we_i,
   input  logic [RET_W-1:0]           rt_hd_i,
   input  logic [RET_W-1:0][AW-1:0]   rt_dst_i,
   input  logic [RET_W-1:0][DW-1:0]   rt_data_i,
   output logic [NARCH-1:0][DW-1:0]   regs_o
);
   logic [NARCH-1:0][DW-1:0] regs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else begin
         for (int r = 0; r < RET_W; r++) begin
            if (rt_we_i[r] && rt_hd_i[r]) regs_q[rt_dst_i[r]] <= rt_data_i[r];
         end
      end
   end

   assign regs_o = regs_q;

   p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rt_we_i & rt_hd_i) == '0) |=> $stable(regs_q));
endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int DEPTH   = 72,
   parameter int NARCH   = 16,
   parameter int DW      = 32,
   parameter int ALLOC_W = 3,
   parameter int WB_W    = 3,
   parameter int LK_W    = 2,
   parameter int RET_W   = 3,
   localparam int TW     = $clog2(DEPTH),
   localparam int AW     = $clog2(NARCH),
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic [ALLOC_W-1:0]      alloc_vld,
   input  logic [ALLOC_W-1:0]      alloc_hd,
   input  logic [ALLOC_W*AW-1:0]   alloc_dst,
   output logic                    alloc_ready,
   output logic [ALLOC_W*TW-1:0]   alloc_tag,
   input  logic [WB_W-1:0]         wb_vld,
   input  logic [WB_W*TW-1:0]      wb_tag,
   input  logic [WB_W*DW-1:0]      wb_data,
   input  logic [LK_W*AW-1:0]      lk_reg,
   output logic [LK_W-1:0]         lk_ready,
   output logic [LK_W*DW-1:0]      lk_val,
   output logic [LK_W*TW-1:0]      lk_tag,
   output logic [RET_W-1:0]        ret_vld
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rob_core: DEPTH must be at least 2");
      end
      if (ALLOC_W < 1 || ALLOC_W > DEPTH) begin : g_bad_alloc
         $error("rob_core: ALLOC_W out of range");
      end
      if (RET_W < 1 || RET_W > DEPTH) begin : g_bad_ret
         $error("rob_core: RET_W out of range");
      end
      if (NARCH < 2 || WB_W < 1 || LK_W < 1 || DW < 1) begin : g_bad_misc
         $error("rob_core: NARCH, WB_W, LK_W, DW out of range");
      end
   endgenerate

   // flat port views
   logic [ALLOC_W-1:0][AW-1:0] al_dst;
   logic [ALLOC_W-1:0][TW-1:0] al_tag;
   logic [WB_W-1:0][TW-1:0]    wb_t;
   logic [WB_W-1:0][DW-1:0]    wb_d;
   logic [LK_W-1:0][AW-1:0]    lk_r;
   logic [LK_W-1:0][DW-1:0]    lk_v;
   logic [LK_W-1:0][TW-1:0]    lk_t;

   assign al_dst    = alloc_dst;
   assign alloc_tag = al_tag;
   assign wb_t      = wb_tag;
   assign wb_d      = wb_data;
   assign lk_r      = lk_reg;
   assign lk_val    = lk_v;
   assign lk_tag    = lk_t;

   // pointers
   logic [TW-1:0] head_q, tail_q, head_n, tail_n;
   logic [CW-1:0] cnt_q, free_w;

   // allocation
   logic [ALLOC_W-1:0][CW-1:0] al_pre;
   logic [CW-1:0]              al_cnt;
   logic [ALLOC_W-1:0]         al_we;

   always_comb begin
      al_cnt = '0;
      for (int i = 0; i < ALLOC_W; i++) begin
         al_pre[i] = al_cnt;
         al_cnt    = al_cnt + CW'(alloc_vld[i]);
      end
   end

   assign free_w      = CW'(DEPTH) - cnt_q;
   assign alloc_ready = (free_w >= al_cnt);
   assign al_we       = alloc_vld & {ALLOC_W{alloc_ready & ~flush}};

   generate
      for (genvar i = 0; i < ALLOC_W; i++) begin : g_atag
         rob_ring_add #(.DEPTH(DEPTH), .OW(CW)) u_atag (
            .base_i(tail_q), .off_i(al_pre[i]), .sum_o(al_tag[i]));
      end
   endgenerate

   rob_ring_add #(.DEPTH(DEPTH), .OW(CW)) u_tail_nxt (
      .base_i(tail_q), .off_i(al_cnt), .sum_o(tail_n));

   // entry storage
   logic [DEPTH-1:0]         done_w;
   logic [DEPTH-1:0][DW-1:0] res_w;
   logic [DEPTH-1:0][AW-1:0] dst_w;
   logic [DEPTH-1:0]         hd_w;

   // retirement
   logic [RET_W-1:0][TW-1:0] rt_idx;
   logic [RET_W-1:0]         rt_we;
   logic [RET_W-1:0][AW-1:0] rt_dst;
   logic [RET_W-1:0]         rt_hd;
   logic [RET_W-1:0][DW-1:0] rt_data;
   logic [CW-1:0]            rt_n;

   generate
      for (genvar i = 0; i < RET_W; i++) begin : g_rtag
         rob_ring_add #(.DEPTH(DEPTH), .OW(CW)) u_rtag (
            .base_i(head_q), .off_i(CW'(i)), .sum_o(rt_idx[i]));
      end
   endgenerate

   always_comb begin
      logic ok;
      ok   = 1'b1;
      rt_n = '0;
      for (int i = 0; i < RET_W; i++) begin
         ok         = ok && (CW'(i) < cnt_q) && done_w[rt_idx[i]];
         rt_we[i]   = ok && !flush;
         rt_n       = rt_n + CW'(rt_we[i]);
         rt_dst[i]  = dst_w[rt_idx[i]];
         rt_hd[i]   = hd_w[rt_idx[i]];
         rt_data[i] = res_w[rt_idx[i]];
      end
   end

   assign ret_vld = rt_we;

   rob_ring_add #(.DEPTH(DEPTH), .OW(CW)) u_head_nxt (
      .base_i(head_q), .off_i(rt_n), .sum_o(head_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         head_q <= head_n;
         if (|al_we) tail_q <= tail_n;
         cnt_q <= cnt_q + ((|al_we) ? al_cnt : '0) - rt_n;
      end
   end

   rob_entry_array #(
      .DEPTH(DEPTH), .DW(DW), .NARCH(NARCH),
      .ALLOC_W(ALLOC_W), .WB_W(WB_W), .RET_W(RET_W)
   ) u_entries (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .al_we_i(al_we), .al_idx_i(al_tag), .al_dst_i(al_dst), .al_hd_i(alloc_hd),
      .wb_vld_i(wb_vld), .wb_tag_i(wb_t), .wb_data_i(wb_d),
      .rt_we_i(rt_we), .rt_idx_i(rt_idx),
      .done_o(done_w), .res_o(res_w), .dst_o(dst_w), .hd_o(hd_w)
   );

   // rename map and committed file
   logic [NARCH-1:0]         busy_w;
   logic [NARCH-1:0][TW-1:0] mtag_w;
   logic [NARCH-1:0][DW-1:0] arch_w;

   rob_rename_map #(
      .DEPTH(DEPTH), .NARCH(NARCH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .al_we_i(al_we), .al_dst_i(al_dst), .al_hd_i(alloc_hd), .al_tag_i(al_tag),
      .rt_we_i(rt_we), .rt_dst_i(rt_dst), .rt_hd_i(rt_hd), .rt_tag_i(rt_idx),
      .busy_o(busy_w), .tag_o(mtag_w)
   );

   rob_commit_file #(.NARCH(NARCH), .DW(DW), .RET_W(RET_W)) u_commit (
      .clk(clk), .rst_n(rst_n),
      .rt_we_i(rt_we), .rt_hd_i(rt_hd), .rt_dst_i(rt_dst), .rt_data_i(rt_data),
      .regs_o(arch_w)
   );

   // source lookup
   lk_src_e            lk_src [LK_W];
   logic [LK_W-1:0][DW-1:0] lk_fwd;

   always_comb begin
      for (int l = 0; l < LK_W; l++) begin
         lk_src[l] = SRC_ARCH;
         lk_fwd[l] = '0;
         lk_t[l]   = '0;
         if (busy_w[lk_r[l]]) begin
            lk_t[l] = mtag_w[lk_r[l]];
            if (done_w[mtag_w[lk_r[l]]]) begin
               lk_src[l] = SRC_ENTRY;
            end else begin
               lk_src[l] = SRC_WAIT;
               for (int w = 0; w < WB_W; w++) begin
                  if (wb_vld[w] && (wb_t[w] == mtag_w[lk_r[l]])) begin
                     lk_src[l] = SRC_FWD;
                     lk_fwd[l] = wb_d[w];
                  end
               end
            end
         end
         case (lk_src[l])
            SRC_ARCH:  begin lk_ready[l] = 1'b1; lk_v[l] = arch_w[lk_r[l]]; end
            SRC_ENTRY: begin lk_ready[l] = 1'b1; lk_v[l] = res_w[lk_t[l]];  end
            SRC_FWD:   begin lk_ready[l] = 1'b1; lk_v[l] = lk_fwd[l];       end
            default:   begin lk_ready[l] = 1'b0; lk_v[l] = '0;              end
         endcase
      end
   end

   p_occupancy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   p_no_alloc_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_ready && !flush) |=> (tail_q == $past(tail_q)));

   p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0 && head_q == '0 && tail_q == '0));

   p_head_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && rt_we == '0) |=> (head_q == $past(head_q)));
endmodule

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
   localparam int DEPTH = 72, NARCH = 16, DW = 32;
   localparam int AL = 3, WB = 3, LK = 2, RT = 3;
   localparam int TW = $clog2(DEPTH), AW = $clog2(NARCH);

   logic clk = 1'b0, rst_n = 1'b0, flush;
   logic [AL-1:0] alloc_vld, alloc_hd;
   logic [AL*AW-1:0] alloc_dst;
   logic alloc_ready;
   logic [AL*TW-1:0] alloc_tag;
   logic [WB-1:0] wb_vld;
   logic [WB*TW-1:0] wb_tag;
   logic [WB*DW-1:0] wb_data;
   logic [LK*AW-1:0] lk_reg;
   logic [LK-1:0] lk_ready;
   logic [LK*DW-1:0] lk_val;
   logic [LK*TW-1:0] lk_tag;
   logic [RT-1:0] ret_vld;

   int n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   rob_core dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_vld(alloc_vld), .alloc_hd(alloc_hd), .alloc_dst(alloc_dst),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data),
      .lk_reg(lk_reg), .lk_ready(lk_ready), .lk_val(lk_val), .lk_tag(lk_tag),
      .ret_vld(ret_vld));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic idle();
      flush = 0; alloc_vld = '0; alloc_hd = '0; alloc_dst = '0;
      wb_vld = '0; wb_tag = '0; wb_data = '0; lk_reg = '0;
   endtask

   task automatic tick();
      @(negedge clk);
      idle();
      #0.5;
   endtask

   task automatic set_al(input int ln, input int dst, input bit hd);
      alloc_vld[ln] = 1'b1; alloc_hd[ln] = hd; alloc_dst[ln*AW +: AW] = AW'(dst);
   endtask

   task automatic set_wb(input int ln, input int tag, input logic [31:0] d);
      wb_vld[ln] = 1'b1; wb_tag[ln*TW +: TW] = TW'(tag); wb_data[ln*DW +: DW] = d;
   endtask

   function automatic logic [31:0] atag(input int ln);
      return 32'(alloc_tag[ln*TW +: TW]);
   endfunction

   // look up register r on lane ln; rdy expected, v is value or tag
   task automatic chk_lk(input string req, input int ln, input int r, input bit rdy, input logic [31:0] v);
      lk_reg[ln*AW +: AW] = AW'(r);
      #0.5;
      chk({req, " lookup ready"}, 32'(lk_ready[ln]), 32'(rdy));
      if (rdy) chk({req, " lookup value"}, lk_val[ln*DW +: DW], v);
      else     chk({req, " lookup tag"}, 32'(lk_tag[ln*TW +: TW]), v);
   endtask

   task automatic t_reset();
      alloc_vld = 3'b111; #0.5;
      chk("R1 ready after reset", 32'(alloc_ready), 1);
      chk("R1 no retire after reset", 32'(ret_vld), 0);
      idle();
      chk_lk("R1", 0, 5, 1, 0);
   endtask

   task automatic t_alloc();
      set_al(0, 1, 1); set_al(1, 2, 1); set_al(2, 3, 1); #0.5;
      chk("R2 lane0 tag", atag(0), 0);
      chk("R2 lane1 tag", atag(1), 1);
      chk("R2 lane2 tag", atag(2), 2);
      tick();
      set_al(0, 4, 1); set_al(2, 5, 1); #0.5;
      chk("R2 gap lane0 tag", atag(0), 3);
      chk("R2 gap lane2 tag", atag(2), 4);
      tick();
      chk_lk("R5 pending r2", 0, 2, 0, 1);
      chk_lk("R5 pending r5", 1, 5, 0, 4);
   endtask

   task automatic t_fwd();
      set_wb(1, 1, 32'hAA);
      chk_lk("R6 forward", 0, 2, 1, 32'hAA);
      tick();
      chk_lk("R4 stored", 0, 2, 1, 32'hAA);
   endtask

   task automatic t_retire();
      chk("R7 head incomplete", 32'(ret_vld), 0);
      set_wb(0, 2, 32'h33); set_wb(2, 4, 32'h55);
      tick();
      chk("R7 blocked by head", 32'(ret_vld), 0);
      chk_lk("R4 out of order", 0, 5, 1, 32'h55);
      idle();
      set_wb(0, 0, 32'h11);
      tick();
      chk("R7 three retire", 32'(ret_vld), 3'b111);
      tick();
      chk("R7 stop at incomplete", 32'(ret_vld), 0);
      chk_lk("R8 commit r1", 0, 1, 1, 32'h11);
      chk_lk("R8 commit r3", 1, 3, 1, 32'h33);
      chk_lk("R8 commit r2", 0, 2, 1, 32'hAA);
   endtask

   task automatic t_rename();
      set_al(0, 7, 1); #0.5; chk("R2 tag5", atag(0), 5);
      tick();
      set_al(0, 7, 1); #0.5; chk("R2 tag6", atag(0), 6);
      tick();
      chk_lk("R10 youngest r7", 0, 7, 0, 6);
      idle();
      set_al(0, 8, 1); set_al(1, 8, 1);
      tick();
      chk_lk("R10 lane order r8", 0, 8, 0, 8);
      idle();
      set_wb(0, 3, 32'h44); set_wb(1, 5, 32'h70);
      tick();
      chk("R7 retire 3..5", 32'(ret_vld), 3'b111);
      tick();
      chk_lk("R9 younger kept", 0, 7, 0, 6);
      chk_lk("R8 commit r4", 1, 4, 1, 32'h44);
   endtask

   task automatic t_nodst();
      set_al(0, 1, 0); #0.5; chk("R2 tag9", atag(0), 9);
      tick();
      chk_lk("R8 no-dest no map", 0, 1, 1, 32'h11);
      idle();
      set_wb(0, 6, 32'h66); set_wb(1, 7, 32'h77); set_wb(2, 8, 32'h88);
      tick();
      set_wb(0, 9, 32'h99); #0.5;
      chk("R7 retire 6..8", 32'(ret_vld), 3'b111);
      tick();
      chk("R7 single retire", 32'(ret_vld), 3'b001);
      tick();
      chk_lk("R8 no-dest keeps r1", 0, 1, 1, 32'h11);
      chk_lk("R9 cleared r7", 1, 7, 1, 32'h66);
      chk_lk("R10 youngest retire r8", 0, 8, 1, 32'h88);
   endtask

   task automatic t_flush();
      set_al(0, 2, 1); #0.5; chk("R2 tag10", atag(0), 10);
      tick();
      chk_lk("R5 before flush", 0, 2, 0, 10);
      idle();
      flush = 1; set_al(0, 3, 1);
      tick();
      chk_lk("R11 r2 committed", 0, 2, 1, 32'hAA);
      chk_lk("R11 flush alloc ignored", 1, 3, 1, 32'h33);
      chk("R11 no retire", 32'(ret_vld), 0);
      idle();
      set_al(0, 0, 0); #0.5;
      chk("R11 tags restart", atag(0), 0);
      tick();
      set_wb(0, 0, 32'h1);
      tick();
      chk("R11 retire after flush", 32'(ret_vld), 3'b001);
      tick();
   endtask

   task automatic t_capacity();
      for (int g = 0; g < DEPTH / 3; g++) begin
         set_al(0, 0, 0); set_al(1, 0, 0); set_al(2, 0, 0); #0.5;
         if (g == DEPTH / 3 - 1) begin
            chk("R12 last group ready", 32'(alloc_ready), 1);
            chk("R2 wrap lane0", atag(0), 70);
            chk("R2 wrap lane1", atag(1), 71);
            chk("R2 wrap lane2", atag(2), 0);
         end
         tick();
      end
      set_al(0, 0, 0); #0.5;
      chk("R12 full not ready", 32'(alloc_ready), 0);
      tick();
      set_wb(0, 1, 32'h5); set_wb(1, 2, 32'h6);
      tick();
      chk("R7 two retire", 32'(ret_vld), 3'b011);
      tick();
      set_al(0, 0, 0); set_al(1, 0, 0); set_al(2, 0, 0); #0.5;
      chk("R3 two free three asked", 32'(alloc_ready), 0);
      tick();
      set_al(0, 0, 0); #0.5;
      chk("R3 one asked ready", 32'(alloc_ready), 1);
      chk("R3 nothing taken in stall", atag(0), 1);
      tick();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      t_reset();
      t_alloc();
      t_fwd();
      t_retire();
      t_rename();
      t_nodst();
      t_flush();
      t_capacity();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule